// File: doc/BRIEF.md
# NAND Die Command Acceptance Filter

This block sits on the device side of a NAND flash die model. It watches the command bytes that reach the die and decides, for each one, whether the die may take it in its present condition. It keeps the two ready levels of the die: `die_rdy` is the interface-ready level and `die_ardy` is the array-ready level. It also records which kind of busy phase is running: a plain one, a cached program or a cached read. Confirm commands move that state, and two completion strobes end the timed phases. The first strobe ends the short phase in which both levels are low. The second ends the array activity that continues after the interface is free again.

The filter also follows the program setup sequence. It knows whether a program or read setup byte is open, so that confirm bytes without a matching setup are refused. It knows whether a two-plane queue entry is pending, so that the cache-clear pulse that normally comes with a program setup is held back while further planes are being queued. Every command gets exactly one verdict pulse, accept or reject, one clock after it is presented. A rejected command changes nothing.

Top module: `nand_cmd_gate`

## Requirements
- R1: After reset `die_rdy`=1 and `die_ardy`=1, and `cmd_ok`, `cmd_bad` and `cache_clr` are all 0.
- R2: A command presented with `cmd_valid` in one cycle produces a one-cycle pulse on exactly one of `cmd_ok` and `cmd_bad` in the next cycle. A rejected command leaves the ready levels, the setup state and the queue unchanged.
- R3: While `die_rdy`=0, only status 0x70, enhanced status 0x78 and reset 0xFF are accepted. Every other byte is rejected.
- R4: During a cached program with `die_rdy`=1 and `die_ardy`=0, only 0x70, 0x78, 0x80, 0x85, 0x10, 0x15 and 0xFF are accepted. Examples of rejected bytes are 0x00 and 0x31.
- R5: Cache-sequential read 0x31 is accepted when the die is fully ready and during a cached read with `die_rdy`=1 and `die_ardy`=0. Cache-last read 0x3F is accepted only during a cached read. Program setup 0x80 is rejected during a cached read.
- R6: An accepted 0x15 drives both levels to 0. A `phase_done` strobe then raises `die_rdy` only. A later `array_done` strobe raises `die_ardy`.
- R7: An accepted 0x31 follows the same pattern as in R6: both levels drop, `phase_done` raises `die_rdy` only, and `array_done` raises `die_ardy`.
- R8: An accepted 0x30, 0x10, 0x11 or 0x3F drives both levels to 0, and a `phase_done` strobe raises both together. `phase_done` has no effect while `die_rdy`=1. `array_done` has no effect unless `die_rdy`=1 and `die_ardy`=0.
- R9: An accepted 0x80 pulses `cache_clr` in the following cycle. The pulse is withheld if an 0x11 has been accepted and no 0x10, 0x15, 0x00 or 0xFF has been accepted since.
- R10: Bytes 0x10, 0x11, 0x15 and 0x85 are accepted only while a program setup (0x80) is open. Byte 0x30 is accepted only while a read setup (0x00) is open. Any of the confirms 0x10, 0x11, 0x15 or 0x30 closes the open setup.
- R11: An accepted 0xFF returns the die to fully ready from any state, closes any open setup and discards a pending two-plane queue, so the next 0x80 pulses `cache_clr`.
- R12: Any byte outside the set {0x00, 0x10, 0x11, 0x15, 0x30, 0x31, 0x3F, 0x70, 0x78, 0x80, 0x85, 0xFF} is always rejected.
- R13: When fully ready, 0x00, 0x80, 0x31, 0x70, 0x78 and 0xFF are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte value |
| phase_done | input | 1 | End of the phase in which both levels are low |
| array_done | input | 1 | End of the array activity that follows a cached phase |
| cmd_ok | output | 1 | Accept pulse, one cycle after the command |
| cmd_bad | output | 1 | Reject pulse, one cycle after the command |
| die_rdy | output | 1 | Interface-ready level |
| die_ardy | output | 1 | Array-ready level |
| cache_clr | output | 1 | Cache-clear pulse, one cycle after an accepted 0x80 |

## Verification
The hardest situations to reach are the withheld cache clear and the command sets that are legal only in the split state (`die_rdy`=1, `die_ardy`=0). Neither can be seen from the ports without first walking a full sequence of setup, confirm and completion strobe. The stimulus table chains these sequences in order. It queues a plane with 0x11 and polls status before the next 0x80, and it opens a cached program and a cached read so that their legal sets can be probed with both allowed and forbidden bytes. Directed steps then apply reset while a cached program is in progress.

// File: rtl/nand_gate_pkg.sv
package nand_gate_pkg;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] OPC_RD_SETUP = 8'h00;
  localparam logic [CMD_W-1:0] OPC_RD_GO    = 8'h30;
  localparam logic [CMD_W-1:0] OPC_RD_SEQ   = 8'h31;
  localparam logic [CMD_W-1:0] OPC_RD_LAST  = 8'h3F;
  localparam logic [CMD_W-1:0] OPC_STAT     = 8'h70;
  localparam logic [CMD_W-1:0] OPC_STAT_X   = 8'h78;
  localparam logic [CMD_W-1:0] OPC_PG_SETUP = 8'h80;
  localparam logic [CMD_W-1:0] OPC_PG_MOVE  = 8'h85;
  localparam logic [CMD_W-1:0] OPC_PG_GO    = 8'h10;
  localparam logic [CMD_W-1:0] OPC_PG_QUEUE = 8'h11;
  localparam logic [CMD_W-1:0] OPC_PG_CACHE = 8'h15;
  localparam logic [CMD_W-1:0] OPC_RESET    = 8'hFF;

  typedef enum logic [1:0] {OP_IDLE, OP_PLAIN, OP_CPROG, OP_CREAD} op_e;
  typedef enum logic [1:0] {SU_NONE, SU_READ, SU_PROG} su_e;

  function automatic logic opc_known(input logic [CMD_W-1:0] c);
    return c inside {OPC_RD_SETUP, OPC_RD_GO, OPC_RD_SEQ, OPC_RD_LAST,
                     OPC_STAT, OPC_STAT_X, OPC_PG_SETUP, OPC_PG_MOVE,
                     OPC_PG_GO, OPC_PG_QUEUE, OPC_PG_CACHE, OPC_RESET};
  endfunction

  function automatic logic opc_always(input logic [CMD_W-1:0] c);
    return c inside {OPC_STAT, OPC_STAT_X, OPC_RESET};
  endfunction

  // Legality of a byte given both ready levels, busy kind and setup state
  function automatic logic opc_legal(input logic [CMD_W-1:0] c,
                                     input logic rdy, input logic ardy,
                                     input op_e op, input su_e su);
    logic ok;
    ok = 1'b0;
    if (opc_always(c)) begin
      ok = 1'b1;
    end else if (rdy && ardy) begin
      case (c)
        OPC_RD_SETUP, OPC_PG_SETUP, OPC_RD_SEQ: ok = 1'b1;
        OPC_RD_GO: ok = (su == SU_READ);
        OPC_PG_MOVE, OPC_PG_GO, OPC_PG_QUEUE, OPC_PG_CACHE: ok = (su == SU_PROG);
        default: ok = 1'b0;
      endcase
    end else if (rdy && op == OP_CPROG) begin
      case (c)
        OPC_PG_SETUP: ok = 1'b1;
        OPC_PG_MOVE, OPC_PG_GO, OPC_PG_CACHE: ok = (su == SU_PROG);
        default: ok = 1'b0;
      endcase
    end else if (rdy && op == OP_CREAD) begin
      ok = (c == OPC_RD_SEQ) || (c == OPC_RD_LAST);
    end
    return ok;
  endfunction
endpackage

// File: rtl/nand_gate_decode.sv
module nand_gate_decode
  import nand_gate_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             rdy,
  input  logic             ardy,
  input  op_e              op,
  input  su_e              su,
  output logic             legal,
  output logic             known,
  output logic             always_ok
);
  always_comb begin
    known     = opc_known(cmd_byte);
    always_ok = opc_always(cmd_byte);
    legal     = opc_legal(cmd_byte, rdy, ardy, op, su);
  end
endmodule

// File: rtl/nand_gate_busy.sv
module nand_gate_busy
  import nand_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             phase_done,
  input  logic             array_done,
  output logic             rdy,
  output logic             ardy,
  output op_e              op
);
  logic enter_plain, enter_cprog, enter_cread, take_reset;
  logic phase_end, array_end, cached_op;

  assign enter_plain = take && (cmd_byte inside {OPC_RD_GO, OPC_PG_GO, OPC_PG_QUEUE, OPC_RD_LAST});
  assign enter_cprog = take && (cmd_byte == OPC_PG_CACHE);
  assign enter_cread = take && (cmd_byte == OPC_RD_SEQ);
  assign take_reset  = take && (cmd_byte == OPC_RESET);
  assign phase_end   = !take && !rdy && phase_done;
  assign array_end   = !take && rdy && !ardy && array_done;
  assign cached_op   = (op == OP_CPROG) || (op == OP_CREAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy  <= 1'b1;
      ardy <= 1'b1;
      op   <= OP_IDLE;
    end else if (take_reset) begin
      rdy  <= 1'b1;
      ardy <= 1'b1;
      op   <= OP_IDLE;
    end else if (enter_plain || enter_cprog || enter_cread) begin
      rdy  <= 1'b0;
      ardy <= 1'b0;
      op   <= enter_cprog ? OP_CPROG : (enter_cread ? OP_CREAD : OP_PLAIN);
    end else if (phase_end) begin
      rdy <= 1'b1;
      if (!cached_op) begin
        ardy <= 1'b1;
        op   <= OP_IDLE;
      end
    end else if (array_end) begin
      ardy <= 1'b1;
      op   <= OP_IDLE;
    end
  end

  AST_BUSY_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |-> !ardy); // R6
  AST_CACHED_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end && cached_op) |=> (rdy && !ardy)); // R7
  AST_PLAIN_BOTH_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end && op == OP_PLAIN) |=> (rdy && ardy)); // R8
  AST_RESET_READY: assert property (@(posedge clk) disable iff (!rst_n)
    take_reset |=> (rdy && ardy)); // R11
endmodule

// File: rtl/nand_gate_setup.sv
module nand_gate_setup
  import nand_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [CMD_W-1:0] cmd_byte,
  output su_e              su,
  output logic             clr_pulse
);
  logic tp_queued;
  logic take_pg_setup, take_close, take_queue, take_drop_q;

  assign take_pg_setup = take && (cmd_byte == OPC_PG_SETUP);
  assign take_queue    = take && (cmd_byte == OPC_PG_QUEUE);
  assign take_close    = take && (cmd_byte inside {OPC_RD_GO, OPC_PG_GO, OPC_PG_QUEUE,
                                                   OPC_PG_CACHE, OPC_RESET});
  assign take_drop_q   = take && (cmd_byte inside {OPC_PG_GO, OPC_PG_CACHE,
                                                   OPC_RD_SETUP, OPC_RESET});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      su        <= SU_NONE;
      tp_queued <= 1'b0;
      clr_pulse <= 1'b0;
    end else begin
      clr_pulse <= take_pg_setup && !tp_queued;
      if (take_pg_setup)
        su <= SU_PROG;
      else if (take && cmd_byte == OPC_RD_SETUP)
        su <= SU_READ;
      else if (take_close)
        su <= SU_NONE;
      if (take_queue)
        tp_queued <= 1'b1;
      else if (take_drop_q)
        tp_queued <= 1'b0;
    end
  end

  AST_CLR_WITHHELD: assert property (@(posedge clk) disable iff (!rst_n)
    (take_pg_setup && tp_queued) |=> !clr_pulse); // R9
  AST_CLR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> $past(take_pg_setup)); // R9
  AST_RESET_DROPS_Q: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_byte == OPC_RESET) |=> (!tp_queued && su == SU_NONE)); // R11
endmodule

// File: rtl/nand_cmd_gate.sv
module nand_cmd_gate
  import nand_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             phase_done,
  input  logic             array_done,
  output logic             cmd_ok,
  output logic             cmd_bad,
  output logic             die_rdy,
  output logic             die_ardy,
  output logic             cache_clr
);
  op_e  op;
  su_e  su;
  logic legal, known, always_ok, take;

  nand_gate_decode u_decode (
    .cmd_byte  (cmd_byte),
    .rdy       (die_rdy),
    .ardy      (die_ardy),
    .op        (op),
    .su        (su),
    .legal     (legal),
    .known     (known),
    .always_ok (always_ok)
  );

  assign take = cmd_valid && legal;

  nand_gate_busy u_busy (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .cmd_byte   (cmd_byte),
    .phase_done (phase_done),
    .array_done (array_done),
    .rdy        (die_rdy),
    .ardy       (die_ardy),
    .op         (op)
  );

  nand_gate_setup u_setup (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .cmd_byte  (cmd_byte),
    .su        (su),
    .clr_pulse (cache_clr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_ok  <= 1'b0;
      cmd_bad <= 1'b0;
    end else begin
      cmd_ok  <= take;
      cmd_bad <= cmd_valid && !legal;
    end
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ok && cmd_bad)); // R2
  AST_VERDICT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (cmd_ok || cmd_bad)); // R2
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !legal && !phase_done && !array_done) |=> ($stable(die_rdy) && $stable(die_ardy))); // R2
  AST_BUSY_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !die_rdy && !always_ok) |=> cmd_bad); // R3
  AST_UNKNOWN_REJ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !known) |=> cmd_bad); // R12
endmodule

// File: tb/test_nand_cmd_gate.sv
module test_nand_cmd_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       phase_done = 1'b0;
  logic       array_done = 1'b0;
  logic       cmd_ok, cmd_bad, die_rdy, die_ardy, cache_clr;

  always #4 clk = ~clk; // 125 MHz

  nand_cmd_gate i_nand_cmd_gate (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .phase_done(phase_done), .array_done(array_done), .cmd_ok(cmd_ok),
    .cmd_bad(cmd_bad), .die_rdy(die_rdy), .die_ardy(die_ardy), .cache_clr(cache_clr)
  );

  // exp bits: {ok, bad, rdy, ardy, clr}; dn bits: {phase_done, array_done}
  typedef struct packed {
    logic       v;
    logic [7:0] c;
    logic [1:0] dn;
    logic [4:0] exp;
    logic [3:0] rq;
  } vec_t;

  localparam int N = 50;
  localparam vec_t TBL [N] = '{
    '{1'b1, 8'h80, 2'b00, 5'b10111, 4'd9},  // R9 fresh setup clears
    '{1'b1, 8'h10, 2'b00, 5'b10000, 4'd8},  // R8
    '{1'b1, 8'h00, 2'b00, 5'b01000, 4'd3},  // R3
    '{1'b1, 8'h70, 2'b00, 5'b10000, 4'd3},  // R3
    '{1'b0, 8'h00, 2'b10, 5'b00110, 4'd8},  // R8
    '{1'b1, 8'h10, 2'b00, 5'b01110, 4'd10}, // R10
    '{1'b1, 8'h30, 2'b00, 5'b01110, 4'd10}, // R10
    '{1'b1, 8'h42, 2'b00, 5'b01110, 4'd12}, // R12
    '{1'b1, 8'h3F, 2'b00, 5'b01110, 4'd5},  // R5
    '{1'b1, 8'h80, 2'b00, 5'b10111, 4'd9},  // R9
    '{1'b1, 8'h11, 2'b00, 5'b10000, 4'd8},  // R8
    '{1'b1, 8'h78, 2'b00, 5'b10000, 4'd3},  // R3
    '{1'b0, 8'h00, 2'b10, 5'b00110, 4'd8},  // R8
    '{1'b1, 8'h70, 2'b00, 5'b10110, 4'd13}, // R13
    '{1'b1, 8'h80, 2'b00, 5'b10110, 4'd9},  // R9 withheld
    '{1'b1, 8'h85, 2'b00, 5'b10110, 4'd10}, // R10
    '{1'b1, 8'h15, 2'b00, 5'b10000, 4'd6},  // R6
    '{1'b1, 8'h80, 2'b00, 5'b01000, 4'd3},  // R3
    '{1'b0, 8'h00, 2'b10, 5'b00100, 4'd6},  // R6
    '{1'b1, 8'h31, 2'b00, 5'b01100, 4'd4},  // R4
    '{1'b1, 8'h00, 2'b00, 5'b01100, 4'd4},  // R4
    '{1'b1, 8'h80, 2'b00, 5'b10101, 4'd4},  // R4
    '{1'b1, 8'h85, 2'b00, 5'b10100, 4'd4},  // R4
    '{1'b1, 8'h15, 2'b00, 5'b10000, 4'd6},  // R6
    '{1'b0, 8'h00, 2'b10, 5'b00100, 4'd6},  // R6
    '{1'b0, 8'h00, 2'b01, 5'b00110, 4'd6},  // R6
    '{1'b0, 8'h00, 2'b11, 5'b00110, 4'd8},  // R8 ignored when ready
    '{1'b1, 8'h31, 2'b00, 5'b10000, 4'd7},  // R7
    '{1'b0, 8'h00, 2'b01, 5'b00000, 4'd8},  // R8 ignored when busy
    '{1'b0, 8'h00, 2'b10, 5'b00100, 4'd7},  // R7
    '{1'b1, 8'h31, 2'b00, 5'b10000, 4'd5},  // R5
    '{1'b0, 8'h00, 2'b10, 5'b00100, 4'd7},  // R7
    '{1'b1, 8'h80, 2'b00, 5'b01100, 4'd5},  // R5
    '{1'b1, 8'h3F, 2'b00, 5'b10000, 4'd5},  // R5
    '{1'b0, 8'h00, 2'b10, 5'b00110, 4'd8},  // R8
    '{1'b1, 8'h00, 2'b00, 5'b10110, 4'd13}, // R13
    '{1'b1, 8'h30, 2'b00, 5'b10000, 4'd10}, // R10
    '{1'b1, 8'hFF, 2'b00, 5'b10110, 4'd11}, // R11
    '{1'b1, 8'h80, 2'b00, 5'b10111, 4'd9},  // R9
    '{1'b1, 8'h11, 2'b00, 5'b10000, 4'd8},  // R8
    '{1'b1, 8'hFF, 2'b00, 5'b10110, 4'd11}, // R11
    '{1'b1, 8'h80, 2'b00, 5'b10111, 4'd11}, // R11 queue dropped
    '{1'b1, 8'h10, 2'b00, 5'b10000, 4'd8},  // R8
    '{1'b0, 8'h00, 2'b10, 5'b00110, 4'd8},  // R8
    '{1'b1, 8'h80, 2'b00, 5'b10111, 4'd9},  // R9
    '{1'b1, 8'h15, 2'b00, 5'b10000, 4'd6},  // R6
    '{1'b0, 8'h00, 2'b10, 5'b00100, 4'd6},  // R6
    '{1'b1, 8'h80, 2'b00, 5'b10101, 4'd4},  // R4
    '{1'b1, 8'h10, 2'b00, 5'b10000, 4'd4},  // R4
    '{1'b0, 8'h00, 2'b10, 5'b00110, 4'd8}   // R8
  };

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  task automatic check(input logic [4:0] exp, input int rq, input string what);
    logic [4:0] act;
    act = {cmd_ok, cmd_bad, die_rdy, die_ardy, cache_clr};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: {ok,bad,rdy,ardy,clr} actual=%b expected=%b", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(5'b00110, 1, "reset state"); // R1
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      cmd_valid  = TBL[i].v;
      cmd_byte   = TBL[i].c;
      phase_done = TBL[i].dn[1];
      array_done = TBL[i].dn[0];
      @(negedge clk);
      check(TBL[i].exp, int'(TBL[i].rq), $sformatf("vector %0d", i));
    end
    cmd_valid = 1'b0; phase_done = 1'b0; array_done = 1'b0;
    // Directed: reset in the middle of a cached program (R1)
    cmd_valid = 1'b1; cmd_byte = 8'h80; @(negedge clk);
    cmd_byte = 8'h15; @(negedge clk);
    cmd_valid = 1'b0; phase_done = 1'b1; @(negedge clk);
    phase_done = 1'b0;
    check(5'b00100, 6, "cached program split before reset"); // R6
    rst_n = 1'b0; @(negedge clk);
    check(5'b00110, 1, "reset during cached program"); // R1
    rst_n = 1'b1; @(negedge clk);
    // Directed: 0x31 accepted from fully ready after reset (R13)
    cmd_valid = 1'b1; cmd_byte = 8'h31; @(negedge clk);
    cmd_valid = 1'b0;
    check(5'b10000, 13, "0x31 from fully ready"); // R13
    @(negedge clk);
    check(5'b00000, 2, "verdict pulse lasts one cycle"); // R2
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end
endmodule